// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Recording

This block sits behind the page table walker of a memory management unit. For every translated access it checks the kind of access against the 3-bit permission field of the final page table entry. It also decides whether the translation cache may receive a writable mapping. When the access is refused, or when the walker already reported a failure, it records the failure in a fault status register and a fault address register and raises a trap request.

The checker is combinational from the check strobe to the fault code, the write grant and the trap lines. The status register and the address register update on the clock edge that follows a fault. A read strobe from the status register's consumer clears the status register on the next edge. If a second fault arrives before the first status has been read, the overflow bit is set and the status is rebuilt from the new fault.

Top module: `mmu_perm_guard`

## Requirements
- R1: The access index is {write, instruction, supervisor}: bit 2 is `acc_kind[0]` (1 = write), bit 1 is `acc_kind[1]` (1 = instruction fetch), bit 0 is `supervisor`. The index is recorded in status bits 7:5 on a fault.
- R2: For a permission check, the fault type is looked up by index (row) and permission code (column) in this table. The codes are 0 = allowed, 2 = protection error, 3 = privilege violation. Rows 0..7 are {0,0,0,0,2,0,3,3}, {0,0,0,0,2,0,0,0}, {2,2,0,0,0,2,3,3}, {2,2,0,0,0,2,0,0}, {2,0,2,0,2,2,3,3}, {2,0,2,0,2,0,2,0}, {2,2,2,0,2,2,3,3} and {2,2,2,0,2,2,2,0}. The type appears in `fault_code[4:2]`, and all other bits of `fault_code` are zero.
- R3: A nonzero `walk_type` overrides the permission check. The fault code is then `walk_lvl` in bits 9:8 and `walk_type` in bits 4:2.
- R4: Without a fault, `wr_grant` is 1 only when `page_modified` is 1 and the write mask for the mode allows the permission code. The user mask over codes 0..7 is {0,1,0,1,0,0,0,0}. The supervisor mask is {0,1,0,1,0,1,0,1}.
- R5: On the edge after a fault, the status register becomes B | (index << 5) | fault_code | 2. B is 1 when the status was nonzero, and 0 otherwise. On the same edge the address register is loaded with `fault_addr`.
- R6: A status read with no fault in the same cycle clears the status register on the next edge. The address register keeps its value.
- R7: When a status read and a fault fall in the same cycle, the fault is recorded and the overflow bit (bit 0) stays 0.
- R8: A fault with `no_fault_mode` at 0 and `traps_enabled` at 1 raises `trap_instr` for an instruction fetch and `trap_data` otherwise, in the same cycle. At most one of the two is high.
- R9: A fault with `no_fault_mode` at 1 or `traps_enabled` at 0 raises no trap and drives `wr_grant` high. The fault is still recorded.
- R10: After reset, both registers are zero. With `chk_valid` low, `fault_code`, `wr_grant` and both trap lines are zero.
- R11: With `chk_valid` and `stat_read` low, the access inputs are ignored. The outputs stay zero and both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | An access is presented for checking this cycle |
| acc_kind | input | 2 | Bit 0 write, bit 1 instruction fetch |
| supervisor | input | 1 | Access made in supervisor mode |
| perm_code | input | 3 | Permission field of the page table entry |
| page_modified | input | 1 | Modified bit of the page table entry |
| walk_lvl | input | 2 | Table level at which the walk failed |
| walk_type | input | 3 | Walk failure type, 0 when the walk succeeded |
| fault_addr | input | ADDR_W | Full address of the access |
| no_fault_mode | input | 1 | Suppress traps on faults |
| traps_enabled | input | 1 | Processor accepts traps |
| stat_read | input | 1 | Status register is being read |
| fault_code | output | 10 | Level in 9:8, fault type in 4:2 |
| wr_grant | output | 1 | Translation cache entry may be writable |
| fsr_q | output | STAT_W | Fault status register |
| far_q | output | ADDR_W | Fault address register |
| trap_instr | output | 1 | Instruction access trap request |
| trap_data | output | 1 | Data access trap request |

## Verification
A status read and the recording of a new fault can fall on the same edge, and they pull the status register in opposite directions. The bench first leaves a nonzero status from an earlier fault. It then presents a refused access together with the read strobe in one cycle. It judges that after that edge the register holds exactly the new fault's image, with bit 0 clear. A separate step checks the other case: a second fault without a read must set bit 0.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;
  localparam int IDX_W    = 3;
  localparam int PERM_W   = 3;
  localparam int TYPE_W   = 3;
  localparam int LVL_W    = 2;
  localparam int CODE_W   = 10;
  localparam int TYPE_LSB = 2;
  localparam int LVL_LSB  = 8;
  localparam int IDX_LSB  = 5;
  localparam int FAV_BIT  = 1;
  localparam int OVF_BIT  = 0;

  // Row r holds 8 two-bit fault types, column c at bits [2c+1:2c].
  localparam logic [7:0][15:0] PERM_ROWS = {
    16'h2A2A, 16'hFA2A, 16'h2222, 16'hFA22,
    16'h080A, 16'hF80A, 16'h0200, 16'hF200
  };
  localparam logic [7:0] WR_MASK_USER = 8'h0A;
  localparam logic [7:0] WR_MASK_SUP  = 8'hAA;

  function automatic logic [TYPE_W-1:0] perm_fault_type(
      input logic [IDX_W-1:0] idx, input logic [PERM_W-1:0] perm);
    logic [15:0] row;
    row = PERM_ROWS[idx];
    return {1'b0, row[2*perm +: 2]};
  endfunction
endpackage

// File: rtl/mmu_access_classify.sv
module mmu_access_classify
  import mmu_perm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chk_valid,
  input  logic [1:0]          acc_kind,
  input  logic                supervisor,
  input  logic [PERM_W-1:0]   perm_code,
  input  logic [LVL_W-1:0]    walk_lvl,
  input  logic [TYPE_W-1:0]   walk_type,
  output logic [IDX_W-1:0]    acc_idx,
  output logic [CODE_W-1:0]   fault_code,
  output logic                fault_hit
);
  logic [TYPE_W-1:0] perm_type;
  logic              walk_fail;

  always_comb begin
    acc_idx   = {acc_kind[0], acc_kind[1], supervisor};
    perm_type = perm_fault_type(acc_idx, perm_code);
    walk_fail = (walk_type != '0);
    fault_code = '0;
    if (chk_valid) begin
      if (walk_fail) begin
        fault_code[LVL_LSB +: LVL_W]   = walk_lvl;
        fault_code[TYPE_LSB +: TYPE_W] = walk_type;
      end else begin
        fault_code[TYPE_LSB +: TYPE_W] = perm_type;
      end
    end
    fault_hit = (fault_code != '0);
  end

  // R2: a permission fault is only ever protection (2) or privilege (3)
  assert_perm_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && walk_type == '0) |->
      (fault_code[TYPE_LSB +: TYPE_W] == 3'd2 || fault_code[TYPE_LSB +: TYPE_W] == 3'd3));
  // R10: nothing is reported without a check strobe
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !fault_hit);
endmodule

// File: rtl/mmu_fault_route.sv
module mmu_fault_route
  import mmu_perm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic              fault_hit,
  input  logic              is_instr,
  input  logic              supervisor,
  input  logic [PERM_W-1:0] perm_code,
  input  logic              page_modified,
  input  logic              no_fault_mode,
  input  logic              traps_enabled,
  output logic              wr_grant,
  output logic              trap_instr,
  output logic              trap_data
);
  logic       suppress;
  logic [7:0] mask;
  logic       mask_ok;

  always_comb begin
    suppress = no_fault_mode || !traps_enabled;
    mask     = supervisor ? WR_MASK_SUP : WR_MASK_USER;
    mask_ok  = mask[perm_code];
    wr_grant = 1'b0;
    if (chk_valid) begin
      wr_grant = fault_hit ? suppress : (page_modified && mask_ok);
    end
    trap_instr = fault_hit && !suppress && is_instr;
    trap_data  = fault_hit && !suppress && !is_instr;
  end

  // R8: only one trap kind per fault
  assert_trap_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_instr, trap_data}));
  // R9: a suppressed fault never traps
  assert_no_trap_suppressed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_fault_mode || !traps_enabled) |-> !(trap_instr || trap_data));
  // R4: a clean grant needs the modified bit
  assert_grant_needs_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant && !fault_hit) |-> page_modified);
endmodule

// File: rtl/mmu_fault_status.sv
module mmu_fault_status
  import mmu_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_hit,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [CODE_W-1:0] fault_code,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              stat_read,
  output logic [STAT_W-1:0] fsr_q,
  output logic [ADDR_W-1:0] far_q
);
  localparam logic [STAT_W-1:0] OVF_VAL = STAT_W'(1) << OVF_BIT;
  localparam logic [STAT_W-1:0] FAV_VAL = STAT_W'(1) << FAV_BIT;

  logic [STAT_W-1:0] fsr_d;
  logic [ADDR_W-1:0] far_d;
  logic              fsr_en;
  logic              far_en;
  logic [STAT_W-1:0] base;

  always_comb begin
    fsr_d  = fsr_q;
    far_d  = far_q;
    fsr_en = 1'b0;
    far_en = 1'b0;
    base   = '0;
    if (fault_hit) begin
      if (fsr_q != '0 && !stat_read) base = OVF_VAL;
      fsr_d  = base | (STAT_W'(acc_idx) << IDX_LSB) | STAT_W'(fault_code) | FAV_VAL;
      far_d  = fault_addr;
      fsr_en = 1'b1;
      far_en = 1'b1;
    end else if (stat_read) begin
      fsr_d  = '0;
      fsr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      if (fsr_en) fsr_q <= fsr_d;
      if (far_en) far_q <= far_d;
    end
  end

  // R5: the address register captures the faulting address
  assert_far_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> far_q == $past(fault_addr));
  // R5: fault address valid bit follows every fault
  assert_fav_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> fsr_q[FAV_BIT]);
  // R5: unread status plus new fault flags overflow
  assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && !stat_read && fsr_q != '0) |=> fsr_q[OVF_BIT]);
  // R6: a plain read clears the status
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && !fault_hit) |=> fsr_q == '0);
  // R7: read and fault together give no overflow
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && fault_hit) |=> !fsr_q[OVF_BIT]);
  // R11: no fault and no read leaves both registers alone
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_hit && !stat_read) |=> ($stable(fsr_q) && $stable(far_q)));
endmodule

// File: rtl/mmu_perm_guard.sv
module mmu_perm_guard
  import mmu_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [1:0]        acc_kind,
  input  logic              supervisor,
  input  logic [2:0]        perm_code,
  input  logic              page_modified,
  input  logic [1:0]        walk_lvl,
  input  logic [2:0]        walk_type,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              no_fault_mode,
  input  logic              traps_enabled,
  input  logic              stat_read,
  output logic [9:0]        fault_code,
  output logic              wr_grant,
  output logic [STAT_W-1:0] fsr_q,
  output logic [ADDR_W-1:0] far_q,
  output logic              trap_instr,
  output logic              trap_data
);
  logic [IDX_W-1:0] acc_idx;
  logic             fault_hit;

  mmu_access_classify i_classify (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_valid  (chk_valid),
    .acc_kind   (acc_kind),
    .supervisor (supervisor),
    .perm_code  (perm_code),
    .walk_lvl   (walk_lvl),
    .walk_type  (walk_type),
    .acc_idx    (acc_idx),
    .fault_code (fault_code),
    .fault_hit  (fault_hit)
  );

  mmu_fault_route i_route (
    .clk           (clk),
    .rst_n         (rst_n),
    .chk_valid     (chk_valid),
    .fault_hit     (fault_hit),
    .is_instr      (acc_kind[1]),
    .supervisor    (supervisor),
    .perm_code     (perm_code),
    .page_modified (page_modified),
    .no_fault_mode (no_fault_mode),
    .traps_enabled (traps_enabled),
    .wr_grant      (wr_grant),
    .trap_instr    (trap_instr),
    .trap_data     (trap_data)
  );

  mmu_fault_status #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) i_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_hit  (fault_hit),
    .acc_idx    (acc_idx),
    .fault_code (fault_code),
    .fault_addr (fault_addr),
    .stat_read  (stat_read),
    .fsr_q      (fsr_q),
    .far_q      (far_q)
  );
endmodule

// File: tb/test_mmu_perm_guard.sv
module test_mmu_perm_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_valid;
  logic [1:0]  acc_kind;
  logic        supervisor;
  logic [2:0]  perm_code;
  logic        page_modified;
  logic [1:0]  walk_lvl;
  logic [2:0]  walk_type;
  logic [31:0] fault_addr;
  logic        no_fault_mode;
  logic        traps_enabled;
  logic        stat_read;
  logic [9:0]  fault_code;
  logic        wr_grant;
  logic [31:0] fsr_q;
  logic [31:0] far_q;
  logic        trap_instr;
  logic        trap_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mmu_perm_guard i_mmu_perm_guard (.*);

  int fault_tbl [8][8] = '{
    '{0,0,0,0,2,0,3,3}, '{0,0,0,0,2,0,0,0},
    '{2,2,0,0,0,2,3,3}, '{2,2,0,0,0,2,0,0},
    '{2,0,2,0,2,2,3,3}, '{2,0,2,0,2,0,2,0},
    '{2,2,2,0,2,2,3,3}, '{2,2,2,0,2,2,2,0}};
  int wr_user [8] = '{0,1,0,1,0,0,0,0};
  int wr_sup  [8] = '{0,1,0,1,0,1,0,1};

  typedef struct packed {
    logic [1:0] kind; logic sup; logic [2:0] perm; logic md;
    logic nf; logic ten; logic [2:0] etype; logic ewr; logic eti; logic etd;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'b00,1'b0,3'd0,1'b1,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0},
    '{2'b01,1'b0,3'd1,1'b1,1'b0,1'b1,3'd0,1'b1,1'b0,1'b0},
    '{2'b01,1'b0,3'd1,1'b0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0},
    '{2'b01,1'b0,3'd0,1'b1,1'b0,1'b1,3'd2,1'b0,1'b0,1'b1},
    '{2'b10,1'b0,3'd6,1'b1,1'b0,1'b1,3'd3,1'b0,1'b1,1'b0},
    '{2'b10,1'b1,3'd6,1'b1,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0},
    '{2'b01,1'b1,3'd5,1'b1,1'b0,1'b1,3'd0,1'b1,1'b0,1'b0},
    '{2'b01,1'b0,3'd5,1'b1,1'b1,1'b1,3'd2,1'b1,1'b0,1'b0},
    '{2'b00,1'b0,3'd6,1'b1,1'b0,1'b0,3'd3,1'b1,1'b0,1'b0},
    '{2'b11,1'b0,3'd3,1'b1,1'b0,1'b1,3'd0,1'b1,1'b0,1'b0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic s, input logic [2:0] p,
                       input logic [31:0] a, input logic rd);
    chk_valid = v; acc_kind = k; supervisor = s; perm_code = p;
    fault_addr = a; stat_read = rd;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 2'b00, 1'b0, 3'd0, 32'h0, 1'b0);
    page_modified = 1'b0; walk_lvl = 2'd0; walk_type = 3'd0;
    no_fault_mode = 1'b0; traps_enabled = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R10 fsr reset", fsr_q, 32'h0);
    chk("R10 far reset", far_q, 32'h0);
    chk("R10 idle outputs", {fault_code, wr_grant, trap_instr, trap_data}, 32'h0);

    // vector table: R1 R2 R4 R8 R9
    foreach (VECS[i]) begin
      drive(1'b1, VECS[i].kind, VECS[i].sup, VECS[i].perm, 32'h100 + i, 1'b0);
      page_modified = VECS[i].md;
      no_fault_mode = VECS[i].nf;
      traps_enabled = VECS[i].ten;
      #1;
      chk($sformatf("R2 vec%0d code", i), {22'd0, fault_code}, {27'd0, VECS[i].etype, 2'b00});
      chk($sformatf("R4/R9 vec%0d grant", i), {31'd0, wr_grant}, {31'd0, VECS[i].ewr});
      chk($sformatf("R8 vec%0d traps", i), {30'd0, trap_instr, trap_data}, {30'd0, VECS[i].eti, VECS[i].etd});
      chk_valid = 1'b0;
      step();
    end
    no_fault_mode = 1'b0; traps_enabled = 1'b1; page_modified = 1'b1;

    // full sweep of index x permission: R1 R2 R4
    for (int idx = 0; idx < 8; idx++) begin
      for (int p = 0; p < 8; p++) begin
        automatic logic [1:0] k = {idx[1], idx[2]};
        automatic int et = fault_tbl[idx][p];
        automatic int ew = (et == 0) ? (idx[0] ? wr_sup[p] : wr_user[p]) : 0;
        drive(1'b1, k, idx[0], p[2:0], 32'h0, 1'b0);
        #1;
        chk($sformatf("R1 R2 idx%0d perm%0d", idx, p), {22'd0, fault_code}, et << 2);
        chk($sformatf("R4 idx%0d perm%0d", idx, p), {31'd0, wr_grant}, ew);
        chk_valid = 1'b0;
        @(negedge clk);
      end
    end

    // R6: plain read clears
    drive(1'b0, 2'b00, 1'b0, 3'd0, 32'h0, 1'b1);
    step();
    chk("R6 clear", fsr_q, 32'h0);

    // R5: first fault, then second fault sets overflow
    drive(1'b1, 2'b01, 1'b0, 3'd0, 32'hDEADB000, 1'b0);
    step();
    chk("R5 first fault fsr", fsr_q, 32'h8A);
    chk("R5 first fault far", far_q, 32'hDEADB000);
    drive(1'b1, 2'b10, 1'b0, 3'd6, 32'h12345678, 1'b0);
    step();
    chk("R5 overflow fsr", fsr_q, 32'h4F);
    chk("R5 second far", far_q, 32'h12345678);

    // R11: bad access without strobe is ignored
    drive(1'b0, 2'b01, 1'b0, 3'd0, 32'hFFFF0000, 1'b0);
    #1;
    chk("R11 outputs quiet", {fault_code, wr_grant, trap_instr, trap_data}, 32'h0);
    step();
    chk("R11 fsr held", fsr_q, 32'h4F);
    chk("R11 far held", far_q, 32'h12345678);

    // R6: read keeps the address
    drive(1'b0, 2'b00, 1'b0, 3'd0, 32'h0, 1'b1);
    step();
    chk("R6 read clears fsr", fsr_q, 32'h0);
    chk("R6 far kept", far_q, 32'h12345678);

    // R7: read and fault in one cycle
    drive(1'b1, 2'b01, 1'b0, 3'd0, 32'hA000, 1'b0);
    step();
    chk("R7 setup fsr", fsr_q, 32'h8A);
    drive(1'b1, 2'b10, 1'b0, 3'd6, 32'hC000, 1'b1);
    step();
    chk("R7 no overflow", fsr_q, 32'h4E);
    chk("R7 far", far_q, 32'hC000);

    // R3: walk error overrides an allowed permission
    drive(1'b1, 2'b00, 1'b1, 3'd0, 32'hD000, 1'b0);
    walk_lvl = 2'd2; walk_type = 3'd1;
    #1;
    chk("R3 walk code", {22'd0, fault_code}, 32'h204);
    chk("R3 R8 data trap", {30'd0, trap_instr, trap_data}, 32'h1);
    step();
    chk("R3 R5 fsr", fsr_q, 32'h227);

    // R9: walk error under no-fault mode
    no_fault_mode = 1'b1;
    drive(1'b1, 2'b10, 1'b0, 3'd2, 32'hE000, 1'b0);
    #1;
    chk("R9 grant", {31'd0, wr_grant}, 32'h1);
    chk("R9 no trap", {30'd0, trap_instr, trap_data}, 32'h0);
    step();
    chk("R9 recorded far", far_q, 32'hE000);
    chk_valid = 1'b0; walk_type = 3'd0; no_fault_mode = 1'b0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule